// File: doc/BRIEF.md
# UART Frame Engine

This block is the serial core of a UART: a transmitter that turns bytes into asynchronous frames on a serial line, and a receiver that recovers bytes from the incoming line. A single 32-bit configuration word sets the frame shape: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. The same word also carries the loopback switch, the transmit flow-control gate, and the software levels and polarity of the two modem output lines. Bit timing comes from an external generator that pulses `tick` sixteen times per bit period.

Bytes enter through a valid/ready handshake and leave as a one-cycle `rx_valid` pulse into a receive queue that sits outside this block. A line break delivers a zero byte with `rx_break` set. A parity or stop-bit fault sets a sticky error flag. The byte is still delivered in that case, so software can decide what to do with it.

Top module: `uart_frame_engine`

## Requirements
- R1: The transmit line idles high. A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the high stop bits. Each bit lasts exactly 16 ticks, and the transmitter is ready again after 16 times the frame length in ticks.
- R2: Configuration bits 3:2 hold the data length: code 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8.
- R3: Configuration bit 1 enables a parity bit after the data. Configuration bit 0 chooses odd parity when it is 1. Even parity makes the parity bit equal to the XOR of the data bits, and odd parity inverts it.
- R4: Configuration bits 5:4 select the stop bits. Value 1 gives one stop bit and value 3 gives two. Only bit 5 is decoded: when it is set, two stop bits are sent.
- R5: `tx_ready` is high only while the transmitter is idle and not held by flow control. A byte is taken on a cycle where `tx_valid` and `tx_ready` are both high, and the start bit appears on `txd` in the next cycle.
- R6: When configuration bit 15 is set and `cts_n` is high, no new frame starts and `txd` stays high. When bit 15 is clear, `cts_n` has no effect.
- R7: The receiver accepts a start bit only after 8 consecutive low ticks, so shorter low pulses produce no byte. It samples each later bit 16 ticks after the previous sample. It delivers each frame as a one-cycle `rx_valid` pulse with the data zero-extended to 8 bits.
- R8: A parity mismatch, or a low stop bit, sets `rx_err`, and the byte is still delivered. `rx_err` stays set until `err_clr` is high for a cycle.
- R9: A frame whose every sample is low, stop bit included, is delivered as a zero byte with `rx_break` high. It does not set `rx_err`. After it, the receiver waits for the line to return high before it looks for the next start bit.
- R10: When configuration bit 14 is set, the receiver takes its input from the transmit line and ignores `rxd`.
- R11: `rts_out` equals configuration bit 6 XOR bit 23, and `dtr_out` equals bit 7 XOR bit 24. Both are registered, so a change in the configuration appears on them one cycle later.
- R12: After reset, `txd` is high, `tx_ready` is high when flow control is off, and `rx_valid`, `rx_err`, `rts_out` and `dtr_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse, 16 per bit period |
| cfg | input | 32 | Frame, loopback, flow and modem-line configuration |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter accepts a byte this cycle |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte, zero-extended |
| rx_break | output | 1 | Delivered byte is a line break |
| err_clr | input | 1 | Clears the sticky receive error |
| rx_err | output | 1 | Sticky parity or stop-bit error |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_out | output | 1 | Request-to-send line level |
| dtr_out | output | 1 | Data-terminal-ready line level |

## Verification
The assertions assume that `tick` is a single-cycle pulse with several clocks between pulses. They also assume that the frame fields of `cfg` do not change while a frame is in flight: the transmitter latches them when it takes a byte, and the receiver latches them when it confirms a start bit. The bench changes `cfg` only while both directions are idle, spaces its ticks four clocks apart, and drives `rxd` and `cts_n` only at falling clock edges. It sweeps every combination of data length, parity mode and stop count, both on the transmit line and through loopback.

// File: rtl/uart_fe_pkg.sv
// Shared configuration decode for the UART frame engine.
// Assumes a 32-bit configuration word whose bit positions are fixed by software.
package uart_fe_pkg;

    localparam int CFG_W = 32;

    typedef struct packed {
        logic       loop_en;    // receiver listens to own transmit line
        logic       cts_gate;   // transmit start waits for clear-to-send
        logic       rts_inv;    // invert request-to-send level
        logic       dtr_inv;    // invert terminal-ready level
        logic       rts_sw;     // software request-to-send level
        logic       dtr_sw;     // software terminal-ready level
        logic       two_stop;   // two stop bits when set
        logic [1:0] len_code;   // data length minus five
        logic       par_en;     // parity bit present
        logic       par_odd;    // odd parity when set
    } frame_cfg_t;

    // Split the configuration word into named fields.
    function automatic frame_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        frame_cfg_t c;
        c.par_odd  = w[0];
        c.par_en   = w[1];
        c.len_code = w[3:2];
        c.two_stop = w[5];
        c.rts_sw   = w[6];
        c.dtr_sw   = w[7];
        c.loop_en  = w[14];
        c.cts_gate = w[15];
        c.rts_inv  = w[23];
        c.dtr_inv  = w[24];
        return c;
    endfunction

endpackage

// File: rtl/uart_fe_tx.sv
// Transmit framer: takes a byte through a valid/ready handshake, builds the
// whole frame as a parallel vector and sends it one bit per OVS ticks.
// Assumes tick is a single-cycle pulse; frame fields are latched at accept.
module uart_fe_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              cts_gate,
    input  logic              cts_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int SLOT_W  = 1 << IDX_W;
    localparam int TC_W    = $clog2(OVS);
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(OVS - 1);

    logic              busy;
    logic [SLOT_W-1:0] frame_q, frame_d;
    logic [IDX_W-1:0]  bidx, last_q, last_d, nb;
    logic [TC_W-1:0]   tcnt;
    logic              par_bit;

    // Assemble start, data, parity and stop bits for the offered byte.
    always_comb begin
        nb      = IDX_W'(DATA_W - 3) + IDX_W'(len_code);
        frame_d = '1;
        frame_d[0] = 1'b0;
        par_bit = par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (IDX_W'(i) < nb) begin
                frame_d[i + 1] = tx_data[i];
                par_bit        = par_bit ^ tx_data[i];
            end
        end
        if (par_en) frame_d[nb + IDX_W'(1)] = par_bit;
        last_d = nb + IDX_W'(par_en) + (two_stop ? IDX_W'(2) : IDX_W'(1));
    end

    assign tx_ready = !busy && (!cts_gate || !cts_n);
    assign txd      = busy ? frame_q[bidx] : 1'b1;

    // Load a frame on handshake, then step through its bits on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            frame_q <= '1;
            bidx    <= '0;
            last_q  <= '0;
            tcnt    <= '0;
        end else if (!busy) begin
            if (tx_valid && tx_ready) begin
                busy    <= 1'b1;
                frame_q <= frame_d;
                last_q  <= last_d;
                bidx    <= '0;
                tcnt    <= '0;
            end
        end else if (tick) begin
            if (tcnt == TC_LAST) begin
                tcnt <= '0;
                if (bidx == last_q) busy <= 1'b0;
                else                bidx <= bidx + IDX_W'(1);
            end else begin
                tcnt <= tcnt + TC_W'(1);
            end
        end
    end

    // R5
    tx_accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (txd == 1'b0));

    // R6
    tx_flow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cts_gate && cts_n) |=> (txd == 1'b1));

endmodule

// File: rtl/uart_fe_rx.sv
// Receive deframer: hunts for a start bit confirmed at mid-bit, samples each
// following bit once per OVS ticks, checks parity and stop, flags breaks.
// Assumes line is already synchronous to clk; frame fields latched at start.
module uart_fe_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              err_clr,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_break,
    output logic              rx_err
);

    localparam int IDX_W = $clog2(DATA_W + 3);
    localparam int TC_W  = $clog2(OVS);
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(OVS - 1);
    localparam logic [TC_W-1:0] TC_MID  = TC_W'(OVS / 2 - 1);

    typedef enum logic [1:0] {S_HUNT, S_START, S_SHIFT, S_REARM} rx_state_t;

    rx_state_t         state;
    logic [TC_W-1:0]   tcnt;
    logic [IDX_W-1:0]  bidx, nb_q;
    logic              pen_q, odd_q, pbit, seen_one;
    logic [DATA_W-1:0] sh;
    logic              slot_end, at_stop, brk_now, par_bad, err_set;

    assign slot_end = (state == S_SHIFT) && tick && (tcnt == TC_LAST);
    assign at_stop  = slot_end && (bidx >= nb_q) && !(pen_q && (bidx == nb_q));
    assign brk_now  = at_stop && !seen_one && !line;
    assign par_bad  = pen_q && (pbit != ((^sh) ^ odd_q));
    assign err_set  = at_stop && !brk_now && (par_bad || !line);

    // Frame sequencing: start qualification, bit sampling, delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_HUNT;
            tcnt     <= '0;
            bidx     <= '0;
            nb_q     <= '0;
            pen_q    <= 1'b0;
            odd_q    <= 1'b0;
            pbit     <= 1'b0;
            seen_one <= 1'b0;
            sh       <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_break <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            case (state)
                S_HUNT: begin
                    if (tick && !line) begin
                        state <= S_START;
                        tcnt  <= TC_W'(1);
                    end
                end
                S_START: begin
                    if (tick) begin
                        if (line) begin
                            state <= S_HUNT;
                        end else if (tcnt == TC_MID) begin
                            state    <= S_SHIFT;
                            tcnt     <= '0;
                            bidx     <= '0;
                            sh       <= '0;
                            seen_one <= 1'b0;
                            nb_q     <= IDX_W'(DATA_W - 3) + IDX_W'(len_code);
                            pen_q    <= par_en;
                            odd_q    <= par_odd;
                        end else begin
                            tcnt <= tcnt + TC_W'(1);
                        end
                    end
                end
                S_SHIFT: begin
                    if (tick) begin
                        if (tcnt == TC_LAST) begin
                            tcnt     <= '0;
                            bidx     <= bidx + IDX_W'(1);
                            seen_one <= seen_one | line;
                            if (bidx < nb_q) begin
                                for (int i = 0; i < DATA_W; i++)
                                    if (IDX_W'(i) == bidx) sh[i] <= line;
                            end else if (pen_q && (bidx == nb_q)) begin
                                pbit <= line;
                            end else begin
                                rx_valid <= 1'b1;
                                rx_data  <= sh;
                                rx_break <= brk_now;
                                state    <= line ? S_HUNT : S_REARM;
                            end
                        end else begin
                            tcnt <= tcnt + TC_W'(1);
                        end
                    end
                end
                S_REARM: begin
                    if (line) state <= S_HUNT;
                end
                default: state <= S_HUNT;
            endcase
        end
    end

    // Sticky error flag: set on a bad frame, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_err <= 1'b0;
        else if (err_clr) rx_err <= 1'b0;
        else if (err_set) rx_err <= 1'b1;
    end

    // R7
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8
    rx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && !err_clr) |=> rx_err);

    // R9
    rx_break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_break) |-> (rx_data == '0));

endmodule

// File: rtl/uart_frame_engine.sv
// UART frame engine top: decodes the configuration word, synchronises the
// receive pin, selects loopback, drives the modem lines and joins tx and rx.
// Assumes the frame fields of cfg change only while both directions are idle.
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_break,
    input  logic              err_clr,
    output logic              rx_err,
    output logic              txd,
    input  logic              rxd,
    input  logic              cts_n,
    output logic              rts_out,
    output logic              dtr_out
);

    frame_cfg_t c;
    logic       txd_int, rxd_s1, rxd_s2, rx_line;
    logic       unused_cfg_bits;

    assign c               = decode_cfg(cfg);
    assign unused_cfg_bits = ^{cfg[CFG_W-1:25], cfg[22:16], cfg[13:8], cfg[4]};

    // Two-stage synchroniser for the asynchronous receive pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_s1 <= 1'b1;
            rxd_s2 <= 1'b1;
        end else begin
            rxd_s1 <= rxd;
            rxd_s2 <= rxd_s1;
        end
    end

    assign rx_line = c.loop_en ? txd_int : rxd_s2;
    assign txd     = txd_int;

    // Registered modem output levels with optional inversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_out <= 1'b0;
            dtr_out <= 1'b0;
        end else begin
            rts_out <= c.rts_sw ^ c.rts_inv;
            dtr_out <= c.dtr_sw ^ c.dtr_inv;
        end
    end

    uart_fe_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .len_code (c.len_code),
        .par_en   (c.par_en),
        .par_odd  (c.par_odd),
        .two_stop (c.two_stop),
        .cts_gate (c.cts_gate),
        .cts_n    (cts_n),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .txd      (txd_int)
    );

    uart_fe_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .line     (rx_line),
        .len_code (c.len_code),
        .par_en   (c.par_en),
        .par_odd  (c.par_odd),
        .err_clr  (err_clr),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_break (rx_break),
        .rx_err   (rx_err)
    );

    // R11
    modem_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg) |=> (rts_out == ($past(cfg[6]) ^ $past(cfg[23]))));

endmodule

// File: tb/uart_frame_engine_tb.sv
// Self-checking bench: sweeps all frame shapes on the transmit line and
// through loopback, then drives receive corner cases from the pin.
module uart_frame_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OVS        = 16;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] cfg = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_break;
    logic        err_clr = 1'b0;
    logic        rx_err;
    logic        txd;
    logic        rxd = 1'b1;
    logic        cts_n = 1'b0;
    logic        rts_out, dtr_out;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    bit   got = 0;
    logic [7:0] got_data = '0;
    bit   got_brk = 0;
    int   tdiv = 0;

    uart_frame_engine u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .err_clr(err_clr), .rx_err(rx_err), .txd(txd), .rxd(rxd),
        .cts_n(cts_n), .rts_out(rts_out), .dtr_out(dtr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick generator, updated just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick = (tdiv == TICK_DIV - 1);
            tdiv = (tdiv + 1) % TICK_DIV;
        end
    end

    // Capture delivered bytes away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            got      = 1;
            got_data = rx_data;
            got_brk  = rx_break;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int nbc, input int pm, input bit two,
                                           input bit lb, input bit flow);
        logic [31:0] w = '0;
        w[1]    = (pm != 0);
        w[0]    = (pm == 2);
        w[3:2]  = 2'(nbc);
        w[5:4]  = two ? 2'd3 : 2'd1;
        w[14]   = lb;
        w[15]   = flow;
        return w;
    endfunction

    function automatic logic [15:0] mk_frame(input logic [7:0] d, input int nbc,
                                             input int pm, input bit two);
        logic [15:0] f = '1;
        int nb = 5 + nbc;
        bit p = (pm == 2);
        f[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            f[1 + i] = d[i];
            p = p ^ d[i];
        end
        if (pm != 0) f[1 + nb] = p;
        return f;
    endfunction

    function automatic int frame_len(input int nbc, input int pm, input bit two);
        return 1 + 5 + nbc + ((pm != 0) ? 1 : 0) + (two ? 2 : 1);
    endfunction

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (tick) k++;
        end
    endtask

    // Send one byte; record txd at the middle of each bit and the tick count.
    task automatic send_byte(input logic [7:0] d, output logic [15:0] seen, output int n);
        seen = '1;
        n = 0;
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        while (!tx_ready && n < 16 * OVS + 8) begin
            if (tick) begin
                if (n % OVS == OVS/2 - 1) seen[n / OVS] = txd;
                n++;
            end
            @(negedge clk);
        end
    endtask

    // Drive a frame onto rxd, then hold the line high.
    task automatic drive_frame(input logic [15:0] f, input int len);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rxd = f[k];
            wait_ticks(OVS);
        end
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(2 * OVS);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    logic [15:0] seen;
    int          n;
    logic [7:0]  exp_d;
    bit          bad;

    initial begin
        // R12 reset state
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R12 txd idle in reset", int'(txd), 1);
        chk(tx_ready == 1'b1, "R12 tx_ready in reset", int'(tx_ready), 1);
        chk(!rx_valid && !rx_err, "R12 rx outputs in reset", int'({rx_valid, rx_err}), 0);
        chk(!rts_out && !dtr_out, "R12 modem lines in reset", int'({rts_out, dtr_out}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(txd == 1'b1, "R1 line idles high", int'(txd), 1);

        // R1 R2 R3 R4 transmit waveform over every frame shape
        for (int nbc = 0; nbc < 4; nbc++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int two = 0; two < 2; two++) begin
                    logic [7:0] d = 8'(8'h35 + (nbc * 6 + pm * 2 + two) * 37);
                    @(negedge clk);
                    cfg = mk_cfg(nbc, pm, two[0], 1'b0, 1'b0);
                    send_byte(d, seen, n);
                    chk(seen == mk_frame(d, nbc, pm, two[0]), "R1 R2 R3 R4 tx frame bits",
                        int'(seen), int'(mk_frame(d, nbc, pm, two[0])));
                    chk(n == OVS * frame_len(nbc, pm, two[0]), "R1 R4 tx frame length in ticks",
                        n, OVS * frame_len(nbc, pm, two[0]));
                end
            end
        end

        // R10 R7 R3 loopback over every frame shape
        pulse_clear();
        for (int nbc = 0; nbc < 4; nbc++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int two = 0; two < 2; two++) begin
                    for (int b = 0; b < 3; b++) begin
                        logic [7:0] d = (b == 0) ? 8'h00 : ((b == 1) ? 8'hA5 : 8'h5E);
                        exp_d = d & 8'((1 << (5 + nbc)) - 1);
                        @(negedge clk);
                        cfg = mk_cfg(nbc, pm, two[0], 1'b1, 1'b0);
                        got = 0;
                        send_byte(d, seen, n);
                        chk(got && got_data == exp_d, "R10 R7 loopback data",
                            int'(got_data), int'(exp_d));
                        chk(!got_brk && !rx_err, "R3 R8 loopback clean frame",
                            int'({got_brk, rx_err}), 0);
                    end
                end
            end
        end

        // R10 external rxd ignored while looping back
        @(negedge clk);
        cfg = mk_cfg(3, 0, 1'b0, 1'b1, 1'b0);
        got = 0;
        rxd = 1'b0;
        wait_ticks(12 * OVS);
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(2 * OVS);
        chk(!got && !rx_err, "R10 rxd ignored in loopback", int'({got, rx_err}), 0);

        // R7 good frame from pin, 8 data bits, no parity
        @(negedge clk);
        cfg = mk_cfg(3, 0, 1'b0, 1'b0, 1'b0);
        wait_ticks(2 * OVS);
        got = 0;
        drive_frame(mk_frame(8'h96, 3, 0, 1'b0), 10);
        chk(got && got_data == 8'h96, "R7 pin frame data", int'(got_data), 8'h96);

        // R7 short low glitch yields no byte
        got = 0;
        @(negedge clk);
        rxd = 1'b0;
        wait_ticks(5);
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(12 * OVS);
        chk(!got, "R7 glitch rejected", int'(got), 0);

        // R8 parity error: even parity, parity bit flipped
        @(negedge clk);
        cfg = mk_cfg(3, 1, 1'b0, 1'b0, 1'b0);
        got = 0;
        drive_frame(mk_frame(8'h96, 3, 1, 1'b0) ^ 16'h0200, 11);
        chk(got && got_data == 8'h96, "R8 byte delivered despite parity error", int'(got_data), 8'h96);
        chk(rx_err == 1'b1, "R8 parity error flagged", int'(rx_err), 1);
        wait_ticks(4 * OVS);
        chk(rx_err == 1'b1, "R8 error stays set", int'(rx_err), 1);
        pulse_clear();
        chk(rx_err == 1'b0, "R8 error cleared", int'(rx_err), 0);

        // R8 stop-bit error, 7 data bits
        @(negedge clk);
        cfg = mk_cfg(2, 0, 1'b0, 1'b0, 1'b0);
        got = 0;
        drive_frame(mk_frame(8'h55, 2, 0, 1'b0) & ~16'h0100, 9);
        chk(got && got_data == 8'h55, "R8 byte delivered despite stop error", int'(got_data), 8'h55);
        chk(rx_err == 1'b1, "R8 stop error flagged", int'(rx_err), 1);
        pulse_clear();

        // R9 break with 6 data bits, even parity, two stops
        @(negedge clk);
        cfg = mk_cfg(1, 1, 1'b1, 1'b0, 1'b0);
        got = 0;
        drive_frame(16'h0000, 11);
        chk(got && got_data == 8'h00, "R9 break delivers zero byte", int'(got_data), 0);
        chk(got_brk == 1'b1, "R9 break flag", int'(got_brk), 1);
        chk(rx_err == 1'b0, "R9 break does not set error", int'(rx_err), 0);
        got = 0;
        drive_frame(mk_frame(8'h2B, 1, 1, 1'b1), 10);
        chk(got && got_data == 8'h2B && !got_brk, "R9 receiver rearms after break",
            int'(got_data), 8'h2B);

        // R5 R6 flow control holds the transmitter
        @(negedge clk);
        cfg = mk_cfg(3, 0, 1'b0, 1'b0, 1'b1);
        cts_n = 1'b1;
        tx_data = 8'hC3;
        tx_valid = 1'b1;
        bad = 0;
        for (int k = 0; k < 40 * TICK_DIV; k++) begin
            @(negedge clk);
            if (tx_ready || !txd) bad = 1;
        end
        chk(!bad, "R6 flow gate holds line idle", int'(bad), 0);
        cts_n = 1'b0;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(txd == 1'b0, "R5 R6 start bit after release", int'(txd), 0);
        for (int k = 0; k < 20 * OVS * TICK_DIV && !tx_ready; k++) @(negedge clk);
        @(negedge clk);
        cfg = mk_cfg(3, 0, 1'b0, 1'b0, 1'b0);
        cts_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R6 cts ignored without gate", int'(tx_ready), 1);
        cts_n = 1'b0;

        // R11 modem line levels over all software and inversion settings
        for (int m = 0; m < 16; m++) begin
            logic [31:0] w = '0;
            w[6]  = m[0];
            w[7]  = m[1];
            w[23] = m[2];
            w[24] = m[3];
            @(negedge clk);
            cfg = w;
            @(negedge clk);
            chk(rts_out == (m[0] ^ m[2]), "R11 rts level", int'(rts_out), int'(m[0] ^ m[2]));
            chk(dtr_out == (m[1] ^ m[3]), "R11 dtr level", int'(dtr_out), int'(m[1] ^ m[3]));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule